// File: doc/BRIEF.md
# Mode-Commanded Buffered Serial Transceiver

This block is an asynchronous serial transceiver with an 8-byte queue on each side. The transmit side sends 8N1 frames: one start bit, eight data bits sent least significant bit first, and one stop bit. The receive side takes frames in with 16x oversampling and samples each bit near its middle. The line rate is chosen live from four preset rates through a 2-bit select. The rate logic derives every divider from the system clock frequency parameter.

A 2-bit command input moves bytes between the queues and an 8-bit bidirectional data port. A LOAD command takes the byte on the port into the transmit queue. A READ command puts the oldest received byte onto the port. A FLUSH command empties both queues. A command acts once, and only when the cycle before it held IDLE. Holding a command, or moving straight from one command to another, does nothing. The port is driven only while a successful READ is held.

Two flow-control signals are active low. The transmitter starts a frame only while the clear-to-send input is low. The ready-to-send output goes high while the receive queue is full. A sticky error flag records four conditions: a bad stop bit, a receive overrun, a LOAD into a full queue, and a READ from an empty queue. A FLUSH clears the flag.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: The bit period is 16*max(1, floor(CLK_HZ/(16*rate))) clocks. The select code picks the rate: 0 gives 9600, 1 gives 19200, 2 gives 38400 and 3 gives 115200 bit/s.
- R2: The tx line idles high. Each frame is one low start bit, then 8 data bits with bit 0 first, then one high stop bit.
- R3: The command codes are 0 IDLE, 1 LOAD, 2 READ and 3 FLUSH, and the cycle after reset counts as IDLE. A non-idle code acts only in the single cycle in which it follows an IDLE cycle. A held command, or a change from one non-idle code to another, has no effect.
- R4: LOAD stores the byte on data_io in the transmit queue. Bytes are transmitted in the order they were loaded.
- R5: One cycle after a READ acts on a non-empty queue, data_io drives the oldest received byte. The value holds while the READ code stays. The port is released in the cycle after the code changes from READ.
- R6: A frame with a high stop bit is stored in the receive queue. rxq_empty_o is high exactly when that queue holds no byte.
- R7: FLUSH empties both queues and clears err_o in the following cycle.
- R8: txq_full_o is high while the transmit queue holds 8 bytes.
- R9: A frame starts only while cts_n_i is low. While cts_n_i is high, queued bytes wait and tx stays idle.
- R10: rts_n_o is high exactly while the receive queue holds 8 bytes.
- R11: err_o goes high and stays high until FLUSH on any of four events. These are: a received stop bit that is low (the byte is dropped), a frame completing while the receive queue is full (the byte is dropped), a LOAD while the transmit queue is full, and a READ while the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| cts_n_i | input | 1 | Clear to send, active low |
| rts_n_o | output | 1 | Ready to send, active low; high when the receive queue is full |
| baud_sel_i | input | 2 | Line rate select |
| cmd_i | input | 2 | Command code |
| data_io | inout | 8 | Byte port: written by LOAD, driven by READ |
| err_o | output | 1 | Sticky error flag |
| txq_full_o | output | 1 | Transmit queue full |
| rxq_empty_o | output | 1 | Receive queue empty |

## Verification
Several rules are checked by the assertions on every cycle:
- the error flag stays set until a FLUSH, and each of the two misuse commands sets it;
- a FLUSH leaves both queues empty and the flag clear;
- the port is released once READ is dropped;
- a frame never begins while clear-to-send is high;
- ready-to-send never signals a full queue while the queue also reports empty.

Other behaviour can only be shown by the bench scenarios. These cover the measured bit time at each rate, the order and bit order of sent and received bytes, and single action on a held command. They also cover dropping a bad-stop frame and keeping the first eight bytes on overrun.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_READ  = 2'd2,
        CMD_FLUSH = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_e;

    localparam int OVS    = 16;
    localparam int BYTE_W = 8;

    function automatic int rate_of(input int sel);
        int r;
        case (sel)
            0:       r = 9600;
            1:       r = 19200;
            2:       r = 38400;
            default: r = 115200;
        endcase
        return r;
    endfunction

    function automatic int div_of(input int clk_hz, input int rate);
        int d;
        d = clk_hz / (rate * OVS);
        if (d < 1) d = 1;
        return d;
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
    import uart_cmd_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int MAX_DIV = div_of(CLK_HZ, rate_of(0));
    localparam int CW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tg_t;

    tg_t           s_d, s_q;
    logic [CW-1:0] last_tab [4];
    logic          wrap;

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign last_tab[g] = CW'(div_of(CLK_HZ, rate_of(g)) - 1);
    end

    always_comb begin
        s_d     = s_q;
        wrap    = (s_q.cnt >= last_tab[sel_i]);
        s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
    end

    assign tick_o = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fq_t;

    fq_t  s_d, s_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (s_q.cnt == CW'(DEPTH));
    assign empty_o = (s_q.cnt == '0);
    assign dout_o  = s_q.mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (clear_i) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = din_i;
                s_d.wp          = adv(s_q.wp);
            end
            if (do_pop) s_d.rp = adv(s_q.rp);
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
    import uart_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cts_n_i,
    input  logic              avail_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              take_o,
    output logic              tx_o,
    output logic              busy_o
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(BYTE_W);

    typedef struct packed {
        line_e             st;
        logic [SW-1:0]     sub;
        logic [BW-1:0]     bitn;
        logic [BYTE_W-1:0] sh;
        logic              txd;
    } txs_t;

    txs_t s_d, s_q;
    logic last_tick;

    always_comb begin
        s_d       = s_q;
        take_o    = 1'b0;
        last_tick = tick_i && (s_q.sub == SW'(OVS - 1));
        if (tick_i && s_q.st != LN_IDLE) s_d.sub = s_q.sub + 1'b1;
        case (s_q.st)
            LN_IDLE: begin
                s_d.txd = 1'b1;
                if (avail_i && !cts_n_i) begin
                    take_o  = 1'b1;
                    s_d.sh  = byte_i;
                    s_d.st  = LN_START;
                    s_d.sub = '0;
                    s_d.txd = 1'b0;
                end
            end
            LN_START: begin
                if (last_tick) begin
                    s_d.st   = LN_DATA;
                    s_d.bitn = '0;
                    s_d.txd  = s_q.sh[0];
                end
            end
            LN_DATA: begin
                if (last_tick) begin
                    if (s_q.bitn == BW'(BYTE_W - 1)) begin
                        s_d.st  = LN_STOP;
                        s_d.txd = 1'b1;
                    end else begin
                        s_d.bitn = s_q.bitn + 1'b1;
                        s_d.sh   = {1'b0, s_q.sh[BYTE_W-1:1]};
                        s_d.txd  = s_q.sh[1];
                    end
                end
            end
            default: begin
                if (last_tick) s_d.st = LN_IDLE;
            end
        endcase
    end

    assign tx_o   = s_q.txd;
    assign busy_o = (s_q.st != LN_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: LN_IDLE, sub: '0, bitn: '0, sh: '0, txd: 1'b1};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
    import uart_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              got_o,
    output logic              bad_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(BYTE_W);

    typedef struct packed {
        logic [1:0]        sync;
        line_e             st;
        logic [SW-1:0]     sub;
        logic [BW-1:0]     bitn;
        logic [BYTE_W-1:0] sh;
        logic              got;
        logic              bad;
    } rxs_t;

    rxs_t s_d, s_q;
    logic rx_s, mid_tick, end_tick;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rx_i};
        s_d.got  = 1'b0;
        s_d.bad  = 1'b0;
        rx_s     = s_q.sync[1];
        mid_tick = tick_i && (s_q.sub == SW'(OVS / 2 - 1));
        end_tick = tick_i && (s_q.sub == SW'(OVS - 1));
        if (tick_i && s_q.st != LN_IDLE) s_d.sub = s_q.sub + 1'b1;
        case (s_q.st)
            LN_IDLE: begin
                if (!rx_s) begin
                    s_d.st  = LN_START;
                    s_d.sub = '0;
                end
            end
            LN_START: begin
                if (mid_tick) begin
                    s_d.sub  = '0;
                    s_d.bitn = '0;
                    s_d.st   = rx_s ? LN_IDLE : LN_DATA;
                end
            end
            LN_DATA: begin
                if (end_tick) begin
                    s_d.sh = {rx_s, s_q.sh[BYTE_W-1:1]};
                    if (s_q.bitn == BW'(BYTE_W - 1)) s_d.st = LN_STOP;
                    else                             s_d.bitn = s_q.bitn + 1'b1;
                end
            end
            default: begin
                if (end_tick) begin
                    s_d.got = rx_s;
                    s_d.bad = !rx_s;
                    s_d.st  = LN_IDLE;
                end
            end
        endcase
    end

    assign got_o  = s_q.got;
    assign bad_o  = s_q.bad;
    assign byte_o = s_q.sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: 2'b11, st: LN_IDLE, sub: '0, bitn: '0, sh: '0, got: 1'b0, bad: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
    import uart_cmd_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       tx_o,
    input  logic       cts_n_i,
    output logic       rts_n_o,
    input  logic [1:0] baud_sel_i,
    input  logic [1:0] cmd_i,
    inout  wire  [7:0] data_io,
    output logic       err_o,
    output logic       txq_full_o,
    output logic       rxq_empty_o
);
    typedef struct packed {
        cmd_e              last_cmd;
        logic              err;
        logic              oe;
        logic [BYTE_W-1:0] rd_byte;
    } ctl_t;

    ctl_t              s_d, s_q;
    logic              tick, tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_take, rx_got, rx_bad, tx_busy, port_oe;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte, port_in;
    cmd_e              cmd;
    logic              armed, go_load, go_read, go_flush, q_push, q_pop;

    assign port_in = data_io;

    always_comb begin
        cmd      = cmd_e'(cmd_i);
        armed    = (s_q.last_cmd == CMD_IDLE);
        go_load  = armed && (cmd == CMD_LOAD);
        go_read  = armed && (cmd == CMD_READ);
        go_flush = armed && (cmd == CMD_FLUSH);
        q_push   = go_load && !tx_full;
        q_pop    = go_read && !rx_empty;

        s_d          = s_q;
        s_d.last_cmd = cmd;
        if (go_flush) begin
            s_d.err = 1'b0;
        end else if ((go_load && tx_full) || (go_read && rx_empty) ||
                     rx_bad || (rx_got && rx_full)) begin
            s_d.err = 1'b1;
        end
        if (q_pop) begin
            s_d.oe      = 1'b1;
            s_d.rd_byte = rx_head;
        end else if (cmd != CMD_READ) begin
            s_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign port_oe     = s_q.oe;
    assign data_io     = port_oe ? s_q.rd_byte : 8'hzz;
    assign err_o       = s_q.err;
    assign txq_full_o  = tx_full;
    assign rxq_empty_o = rx_empty;
    assign rts_n_o     = rx_full;

    uart_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel_i(baud_sel_i), .tick_o(tick)
    );

    uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear_i(go_flush),
        .push_i(q_push), .din_i(port_in), .pop_i(tx_take),
        .dout_o(tx_head), .full_o(tx_full), .empty_o(tx_empty)
    );

    uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear_i(go_flush),
        .push_i(rx_got), .din_i(rx_byte), .pop_i(q_pop),
        .dout_o(rx_head), .full_o(rx_full), .empty_o(rx_empty)
    );

    uart_tx_line u_txl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cts_n_i(cts_n_i),
        .avail_i(!tx_empty), .byte_i(tx_head), .take_o(tx_take),
        .tx_o(tx_o), .busy_o(tx_busy)
    );

    uart_rx_line u_rxl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
        .got_o(rx_got), .bad_o(rx_bad), .byte_o(rx_byte)
    );
endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_i,
    input logic       cts_n_i,
    input logic       rts_n_o,
    input logic       err_o,
    input logic       txq_full_o,
    input logic       rxq_empty_o,
    input logic       tx_busy,
    input logic       port_oe
);
    logic [1:0] prev_cmd;
    logic       c_load, c_read, c_flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_cmd <= 2'd0;
        else        prev_cmd <= cmd_i;
    end

    assign c_load  = (prev_cmd == 2'd0) && (cmd_i == 2'd1);
    assign c_read  = (prev_cmd == 2'd0) && (cmd_i == 2'd2);
    assign c_flush = (prev_cmd == 2'd0) && (cmd_i == 2'd3);

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_flush |=> (!err_o && rxq_empty_o && !txq_full_o));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !c_flush) |=> err_o);

    p_load_full_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_load && txq_full_o) |=> err_o);

    p_read_empty_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_read && rxq_empty_o) |=> err_o);

    p_port_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != 2'd2) |=> !port_oe);

    p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(cts_n_i));

    p_rts_vs_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n_o |-> !rxq_empty_o);
endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .cts_n_i(cts_n_i),
    .rts_n_o(rts_n_o), .err_o(err_o), .txq_full_o(txq_full_o),
    .rxq_empty_o(rxq_empty_o), .tx_busy(tx_busy), .port_oe(port_oe)
);

// File: tb/tb_uart_cmd_ctrl.sv
module tb_uart_cmd_ctrl;
    localparam int CLK_HZ = 1_843_200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       cts_n = 1'b1;
    logic [1:0] baud = 2'd3;
    logic [1:0] cmd = 2'd0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_val = 8'h00;
    logic       tx_line, rts_n, err, full, empty;
    wire  [7:0] bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign bus = tb_oe ? tb_val : 8'hzz;

    always #10 clk = ~clk;

    uart_cmd_ctrl #(.CLK_HZ(CLK_HZ), .FIFO_DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_line), .tx_o(tx_line),
        .cts_n_i(cts_n), .rts_n_o(rts_n), .baud_sel_i(baud), .cmd_i(cmd),
        .data_io(bus), .err_o(err), .txq_full_o(full), .rxq_empty_o(empty)
    );

    function automatic int exp_div(input int sel);
        int rate, d;
        rate = (sel == 0) ? 9600 : (sel == 1) ? 19200 : (sel == 2) ? 38400 : 115200;
        d = CLK_HZ / (16 * rate);
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int exp_period(input int sel);
        return 16 * exp_div(sel);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic issue(input logic [1:0] c);
        cmd = 2'd0;
        step(1);
        cmd = c;
        step(1);
        cmd = 2'd0;
        step(1);
    endtask

    task automatic issue_load(input logic [7:0] v);
        cmd = 2'd0;
        step(1);
        tb_oe  = 1'b1;
        tb_val = v;
        cmd    = 2'd1;
        step(1);
        cmd   = 2'd0;
        tb_oe = 1'b0;
        step(1);
    endtask

    task automatic read_byte(output logic [7:0] b);
        cmd = 2'd0;
        step(1);
        cmd = 2'd2;
        step(1);
        b = bus;
        step(1);
        chk_eq("R5", "read value held", int'(bus), int'(b));
        cmd = 2'd0;
        step(1);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        int p;
        p = exp_period(int'(baud));
        rx_line = 1'b0;
        step(p);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            step(p);
        end
        rx_line = stop_ok;
        step(p);
        rx_line = 1'b1;
        step(2 * p);
    endtask

    task automatic wait_fall(output bit seen);
        int w;
        w = 0;
        while (tx_line !== 1'b0 && w < 20000) begin
            step(1);
            w++;
        end
        seen = (tx_line === 1'b0);
    endtask

    task automatic catch_frame(output logic [7:0] b, output bit ok);
        int  p;
        bit  seen, st;
        p = exp_period(int'(baud));
        b = 8'h00;
        wait_fall(seen);
        if (!seen) begin
            ok = 1'b0;
            return;
        end
        step(p / 2);
        st = (tx_line == 1'b0);
        for (int i = 0; i < 8; i++) begin
            step(p);
            b[i] = tx_line;
        end
        step(p);
        ok = st && (tx_line == 1'b1);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_q [8];
        logic [7:0] b, got;
        bit         ok;
        int         n, p;

        void'($urandom(32'd915));
        step(3);
        rst_n = 1'b1;
        step(2);

        // reset state
        chk_eq("R2", "tx idle after reset", int'(tx_line), 1);
        chk_eq("R10", "rts after reset", int'(rts_n), 0);
        chk_eq("R11", "err after reset", int'(err), 0);
        chk_eq("R8", "full after reset", int'(full), 0);
        chk_eq("R6", "empty after reset", int'(empty), 1);

        // held LOAD acts once; flow control holds tx
        cts_n = 1'b1;
        for (int i = 0; i < 6; i++) issue_load(8'($urandom));
        cmd = 2'd0;
        step(1);
        tb_oe  = 1'b1;
        tb_val = 8'hA5;
        cmd    = 2'd1;
        step(5);
        cmd   = 2'd0;
        tb_oe = 1'b0;
        step(1);
        chk_eq("R3", "held LOAD gives one push (not full)", int'(full), 0);
        chk_eq("R3", "held LOAD raises no error", int'(err), 0);
        issue_load(8'h3C);
        chk_eq("R8", "full after 8 loads", int'(full), 1);
        step(300);
        chk_eq("R9", "tx idle while cts high", int'(tx_line), 1);
        issue_load(8'h11);
        chk_eq("R11", "LOAD into full queue", int'(err), 1);
        step(3);
        chk_eq("R11", "err sticky", int'(err), 1);
        issue(2'd3);
        chk_eq("R7", "flush clears err", int'(err), 0);
        chk_eq("R7", "flush empties tx queue", int'(full), 0);
        chk_eq("R7", "rx queue empty after flush", int'(empty), 1);
        cts_n = 1'b0;
        step(300);
        chk_eq("R7", "nothing sent after flush", int'(tx_line), 1);

        // bit period at each rate, byte 0x55 gives start then bit0 high
        for (int s = 0; s < 4; s++) begin
            bit seen;
            baud = 2'(s);
            p = exp_period(s);
            issue_load(8'h55);
            wait_fall(seen);
            n = 0;
            while (seen && tx_line == 1'b0 && n < 5000) begin
                step(1);
                n++;
            end
            chk(n >= p - exp_div(s) && n <= p, "R1", "start bit length", n, p);
            step(10 * p);
        end

        // ordered transmission of random bytes
        baud  = 2'd2;
        cts_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            exp_q[i] = 8'($urandom);
            issue_load(exp_q[i]);
        end
        chk_eq("R9", "tx still idle with cts high", int'(tx_line), 1);
        cts_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            catch_frame(got, ok);
            chk_eq("R2", "frame start/stop", int'(ok), 1);
            chk_eq("R4", "sent byte in order", int'(got), int'(exp_q[i]));
        end
        step(4 * exp_period(2));

        // receive path
        baud = 2'd0;
        b = 8'($urandom);
        send_frame(b, 1'b1);
        chk_eq("R6", "empty low after frame", int'(empty), 0);
        read_byte(got);
        chk_eq("R6", "slow-rate received byte", int'(got), int'(b));
        baud = 2'd1;
        for (int i = 0; i < 3; i++) begin
            exp_q[i] = 8'($urandom);
            send_frame(exp_q[i], 1'b1);
        end
        for (int i = 0; i < 3; i++) begin
            read_byte(got);
            chk_eq("R5", "read byte in order", int'(got), int'(exp_q[i]));
        end
        chk_eq("R6", "empty after reading all", int'(empty), 1);

        // non-idle to non-idle change is ignored
        b = 8'($urandom);
        send_frame(b, 1'b1);
        cmd = 2'd0;
        step(1);
        tb_oe  = 1'b1;
        tb_val = 8'hC3;
        cmd    = 2'd1;
        step(1);
        tb_oe = 1'b0;
        cmd   = 2'd2;
        step(2);
        cmd = 2'd0;
        step(1);
        chk_eq("R3", "READ after LOAD ignored (not popped)", int'(empty), 0);
        chk_eq("R3", "READ after LOAD raises no error", int'(err), 0);
        read_byte(got);
        chk_eq("R3", "byte still first in queue", int'(got), int'(b));
        catch_frame(got, ok);
        chk_eq("R4", "loaded byte sent", int'(got), 8'hC3);
        step(3 * exp_period(1));

        // READ on empty queue
        issue(2'd2);
        chk_eq("R11", "READ from empty queue", int'(err), 1);
        issue(2'd3);
        chk_eq("R7", "flush clears err again", int'(err), 0);

        // framing error
        baud = 2'd3;
        send_frame(8'h5A, 1'b0);
        chk_eq("R11", "low stop bit sets err", int'(err), 1);
        chk_eq("R11", "bad frame dropped", int'(empty), 1);
        issue(2'd3);

        // overrun
        for (int i = 0; i < 8; i++) begin
            exp_q[i] = 8'($urandom);
            send_frame(exp_q[i], 1'b1);
        end
        chk_eq("R10", "rts high when rx queue full", int'(rts_n), 1);
        chk_eq("R11", "no err at exactly full", int'(err), 0);
        send_frame(8'hEE, 1'b1);
        chk_eq("R11", "overrun sets err", int'(err), 1);
        read_byte(got);
        chk_eq("R6", "first byte after overrun", int'(got), int'(exp_q[0]));
        chk_eq("R10", "rts low after one read", int'(rts_n), 0);
        for (int i = 1; i < 8; i++) begin
            read_byte(got);
            chk_eq("R11", "overrun byte dropped, order kept", int'(got), int'(exp_q[i]));
        end
        chk_eq("R6", "empty after draining", int'(empty), 1);
        issue(2'd3);

        // random rates and bytes through the receiver
        for (int i = 0; i < 6; i++) begin
            baud = 2'($urandom_range(1, 3));
            b    = 8'($urandom);
            send_frame(b, 1'b1);
            read_byte(got);
            chk_eq("R6", "random receive", int'(got), int'(b));
        end
        chk_eq("R11", "no error in clean traffic", int'(err), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule